// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a parameterized set of interrupt request lines (32 by default, at most 240) and presents the most urgent serviceable one to a small processor. For every line it keeps an enable flag, a pending flag and an 8-bit urgency value. Software never writes enable or pending state directly. It uses paired banks of write-one-to-set and write-one-to-clear registers instead, so a read-modify-write race cannot occur. A rising edge on a request line latches the pending flag. Software can also force a line pending with no hardware cause.

A combinational search picks the pending, enabled line that has the smallest urgency value. When two lines tie, the lower line number wins. A small sequencer with three states (`ST_IDLE`, `ST_SIGNAL`, `ST_HOLDOFF`) turns the search result into a registered request. `ST_IDLE` goes to `ST_SIGNAL` when a candidate exists. `ST_SIGNAL` stays there, recapturing the winner each cycle, while a candidate remains. It falls back to `ST_IDLE` when none remains, and it moves to `ST_HOLDOFF` on an acknowledge. `ST_HOLDOFF` holds the request low for exactly one cycle and then goes to `ST_SIGNAL` or `ST_IDLE`, depending on whether a candidate is left. The acknowledge clears the pending flag of the reported line. The vector address is a software-relocatable base plus four times the line number. A wake-on-pending control bit produces a one-cycle event whenever any pending flag rises, including the flag of a disabled line.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all enables, pending flags, urgency values, the table base and the wake control are zero. `irq_o`, `irq_id_o`, `vec_o` and `wake_o` are also zero.
- R2: Writing a 1 bit to a set-enable word enables the matching line. A 0 bit leaves it unchanged. Reading either enable bank returns the current enable flags.
- R3: Writing a 1 bit to a clear-enable word disables the matching line. A disabled line is never reported, even while its pending flag stays set.
- R4: Writing a 1 bit to a set-pending word makes the matching line pending without any hardware request. Reading either pending bank returns the current pending flags.
- R5: Writing a 1 bit to a clear-pending word removes the pending flag. A 0-to-1 transition on `irq_req[n]` sets pending n. When that transition and a clear of the same line fall in one cycle, the line ends pending. A request held high does not set the flag again.
- R6: The map uses byte addresses. Address 0x000 bit 0 is wake enable, and 0x004 is the 32-bit table base. Line n sits in bank word n/32, bit n%32. Bank word k is set-enable at 0x040+4k, clear-enable at 0x080+4k, set-pending at 0x0C0+4k and clear-pending at 0x100+4k. The urgency of line n is at 0x200+4*(n/4), bits 8*(n%4)+7 down to 8*(n%4). Reads of urgency words return the stored values.
- R7: `irq_o` is high only while some line is both pending and enabled. `irq_id_o` names the one with the smallest urgency value, and a tie goes to the lower line number.
- R8: `vec_o` equals the table base plus 4 times `irq_id_o`, modulo 2^32.
- R9: Holding `ack_i` high for one cycle while `irq_o` is high clears the pending flag of the line in `irq_id_o`. `irq_o` is then low for the next cycle, after which the remaining lines are arbitrated again.
- R10: While wake enable is 1, `wake_o` is high for one cycle in the cycle after any pending flag goes from 0 to 1, whether or not that line is enabled. While wake enable is 0, `wake_o` stays low.
- R11: Take a register write or request edge that makes a line the winner at clock edge E. `irq_o`, `irq_id_o` and `vec_o` show it from clock edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_req | input | NUM_IRQ | Request lines, rising edge latches pending |
| ack_i | input | 1 | Acknowledge of the reported line |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_id_o | output | 8 | Number of the reported line |
| vec_o | output | 32 | Vector address of the reported line |
| wake_o | output | 1 | One-cycle wake event |

## Verification
The bench builds the block with NUM_IRQ = 40. This gives a second bank word that is only partly populated, so the mapping of lines above 31 can be tested. It also spreads the urgency values over ten words, so a winner can come from either bank. Random urgency values are limited to four levels, so ties and the lower-number rule come up often. Directed cases cover the one-cycle request latency, the holdoff after an acknowledge, an edge-versus-clear collision, and the wake event for a disabled line.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int ID_W   = 8;
    localparam int PRIO_W = 8;

    // Region code taken from bus_addr[9:6]
    localparam logic [3:0] RGN_CTRL  = 4'h0;
    localparam logic [3:0] RGN_SETEN = 4'h1;
    localparam logic [3:0] RGN_CLREN = 4'h2;
    localparam logic [3:0] RGN_SETPD = 4'h3;
    localparam logic [3:0] RGN_CLRPD = 4'h4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SIGNAL  = 2'd1,
        ST_HOLDOFF = 2'd2
    } seq_state_e;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_sel,
    input  logic                             bus_we,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    input  logic [NUM_IRQ-1:0]               irq_req,
    input  logic [NUM_IRQ-1:0]               ack_clr,
    output logic [NUM_IRQ-1:0]               en_q,
    output logic [NUM_IRQ-1:0]               pend_q,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio_q,
    output logic [DATA_W-1:0]                vbase_q,
    output logic                             wake_en_q,
    output logic                             wake_o
);
    localparam int LANES = DATA_W / PRIO_W;

    logic       wr;
    logic [3:0] rgn;
    logic [3:0] bank;
    logic [6:0] pword;
    logic       unused_addr_lsb;

    assign wr    = bus_sel & bus_we;
    assign rgn   = bus_addr[9:6];
    assign bank  = bus_addr[5:2];
    assign pword = bus_addr[8:2];
    assign unused_addr_lsb = |bus_addr[1:0];

    logic [NUM_IRQ-1:0] set_en, clr_en, set_pd, clr_pd;
    logic [NUM_IRQ-1:0] req_q, rise, pend_d;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        localparam int BK = i / DATA_W;
        localparam int BT = i % DATA_W;
        localparam int PW = i / LANES;
        localparam int PL = i % LANES;

        logic bit_hit;
        assign bit_hit   = wr && !bus_addr[9] && (bank == BK[3:0]) && bus_wdata[BT];
        assign set_en[i] = bit_hit && (rgn == RGN_SETEN);
        assign clr_en[i] = bit_hit && (rgn == RGN_CLREN);
        assign set_pd[i] = bit_hit && (rgn == RGN_SETPD);
        assign clr_pd[i] = bit_hit && (rgn == RGN_CLRPD);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[i] <= '0;
            end else if (wr && bus_addr[9] && (pword == PW[6:0])) begin
                prio_q[i] <= bus_wdata[PRIO_W*PL +: PRIO_W];
            end
        end
    end

    // A new request edge wins over any clear in the same cycle
    assign rise   = irq_req & ~req_q;
    assign pend_d = (pend_q & ~clr_pd & ~ack_clr) | set_pd | rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            pend_q    <= '0;
            req_q     <= '0;
            vbase_q   <= '0;
            wake_en_q <= 1'b0;
            wake_o    <= 1'b0;
        end else begin
            en_q   <= (en_q & ~clr_en) | set_en;
            pend_q <= pend_d;
            req_q  <= irq_req;
            wake_o <= wake_en_q & (|(pend_d & ~pend_q));
            if (wr && (rgn == RGN_CTRL) && (bank == 4'd0)) begin
                wake_en_q <= bus_wdata[0];
            end
            if (wr && (rgn == RGN_CTRL) && (bank == 4'd1)) begin
                vbase_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[9]) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (pword == 7'(i / LANES)) begin
                    bus_rdata[PRIO_W*(i % LANES) +: PRIO_W] = prio_q[i];
                end
            end
        end else begin
            case (rgn)
                RGN_CTRL: begin
                    if (bank == 4'd0) bus_rdata[0] = wake_en_q;
                    if (bank == 4'd1) bus_rdata    = vbase_q;
                end
                RGN_SETEN, RGN_CLREN: begin
                    for (int i = 0; i < NUM_IRQ; i++) begin
                        if (bank == 4'(i / DATA_W)) bus_rdata[i % DATA_W] = en_q[i];
                    end
                end
                RGN_SETPD, RGN_CLRPD: begin
                    for (int i = 0; i < NUM_IRQ; i++) begin
                        if (bank == 4'(i / DATA_W)) bus_rdata[i % DATA_W] = pend_q[i];
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]             cand,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
    output logic                           found,
    output logic [ID_W-1:0]                win_id
);
    logic [PRIO_W-1:0] best;

    // Ascending scan with strict compare: equal urgency keeps the lower index
    always_comb begin
        found  = 1'b0;
        win_id = '0;
        best   = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!found || (prio[i] < best))) begin
                found  = 1'b1;
                best   = prio[i];
                win_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               found,
    input  logic [ID_W-1:0]    win_id,
    input  logic [DATA_W-1:0]  vbase,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    irq_id_o,
    output logic [DATA_W-1:0]  vec_o,
    output logic [NUM_IRQ-1:0] ack_clr
);
    seq_state_e state_q, state_d;
    logic       ack_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (found) state_d = ST_SIGNAL;
            ST_SIGNAL: begin
                if (ack_i)       state_d = ST_HOLDOFF;
                else if (!found) state_d = ST_IDLE;
            end
            ST_HOLDOFF: state_d = found ? ST_SIGNAL : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_id_o <= '0;
            vec_o    <= '0;
        end else if (state_d == ST_SIGNAL) begin
            irq_id_o <= win_id;
            vec_o    <= vbase + DATA_W'({win_id, 2'b00});
        end
    end

    assign irq_o    = (state_q == ST_SIGNAL);
    assign ack_fire = irq_o & ack_i;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ack
        assign ack_clr[i] = ack_fire && (irq_id_o == ID_W'(i));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    irq_id_o,
    output logic [DATA_W-1:0]  vec_o,
    output logic               wake_o
);
    logic [NUM_IRQ-1:0]             en_q, pend_q, ack_clr;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
    logic [DATA_W-1:0]              vbase_q;
    logic                           wake_en_q;
    logic                           found;
    logic [ID_W-1:0]                win_id;

    irq_regfile #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .ack_clr(ack_clr),
        .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q),
        .vbase_q(vbase_q), .wake_en_q(wake_en_q), .wake_o(wake_o)
    );

    irq_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .cand(pend_q & en_q), .prio(prio_q),
        .found(found), .win_id(win_id)
    );

    irq_sequencer #(.NUM_IRQ(NUM_IRQ)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .found(found), .win_id(win_id), .vbase(vbase_q), .ack_i(ack_i),
        .irq_o(irq_o), .irq_id_o(irq_id_o), .vec_o(vec_o), .ack_clr(ack_clr)
    );
endmodule

// File: rtl/irq_ctrl_sva.sv
module irq_ctrl_sva
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic               ack_i,
    input logic               irq_o,
    input logic [ID_W-1:0]    irq_id_o,
    input logic [DATA_W-1:0]  vec_o,
    input logic               wake_o,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [NUM_IRQ-1:0] pend_q,
    input logic [DATA_W-1:0]  vbase_q,
    input logic               wake_en_q
);
    logic [NUM_IRQ-1:0] cand_q, req_prev, rise_v;
    logic               win_is_cand;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q   <= '0;
            req_prev <= '0;
        end else begin
            cand_q   <= pend_q & en_q;
            req_prev <= irq_req;
        end
    end

    assign rise_v      = irq_req & ~req_prev;
    assign win_is_cand = |(cand_q & ({{(NUM_IRQ-1){1'b0}}, 1'b1} << irq_id_o));

    // R7: a reported line was pending and enabled when it was picked
    a_r7_winner_serviceable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> win_is_cand);

    // R8: vector follows the base seen when the winner was captured
    a_r8_vector_formed: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o == $past(vbase_q) + DATA_W'({irq_id_o, 2'b00})));

    // R9: one quiet cycle follows an acknowledge
    a_r9_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    // R5: every request edge leaves its line pending
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_v) |=> ((pend_q & $past(rise_v)) == $past(rise_v)));

    // R10: wake events only while wake enable was set
    a_r10_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(wake_en_q));
endmodule

bind prio_irq_ctrl irq_ctrl_sva #(.NUM_IRQ(NUM_IRQ)) u_sva (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ack_i(ack_i),
    .irq_o(irq_o), .irq_id_o(irq_id_o), .vec_o(vec_o), .wake_o(wake_o),
    .en_q(en_q), .pend_q(pend_q), .vbase_q(vbase_q), .wake_en_q(wake_en_q)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    localparam int NI = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NI-1:0] irq_req = '0;
    logic          ack_i = 1'b0;
    logic          irq_o, wake_o;
    logic [7:0]    irq_id_o;
    logic [31:0]   vec_o;

    int tests = 0;
    int fails = 0;

    // bench model
    logic [NI-1:0] en_m = '0, pd_m = '0, rq_m = '0;
    logic [7:0]    pr_m [NI];
    logic [31:0]   vb_m = '0;
    logic          wk_m = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_IRQ(NI)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .ack_i(ack_i), .irq_o(irq_o), .irq_id_o(irq_id_o),
        .vec_o(vec_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic void model_write(input logic [9:0] a, input logic [31:0] d);
        if (a[9]) begin
            for (int i = 0; i < NI; i++)
                if (7'(i / 4) == a[8:2]) pr_m[i] = d[8*(i%4) +: 8];
        end else if (a[9:6] == 4'h0) begin
            if (a[5:2] == 4'd0) wk_m = d[0];
            if (a[5:2] == 4'd1) vb_m = d;
        end else begin
            for (int i = 0; i < NI; i++) begin
                if (4'(i / 32) == a[5:2] && d[i % 32]) begin
                    case (a[9:6])
                        4'h1: en_m[i] = 1'b1;
                        4'h2: en_m[i] = 1'b0;
                        4'h3: pd_m[i] = 1'b1;
                        4'h4: pd_m[i] = 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    endfunction

    function automatic logic [8:0] exp_win();
        logic f = 1'b0;
        logic [7:0] id = '0, best = '1;
        for (int i = 0; i < NI; i++) begin
            if (en_m[i] && pd_m[i] && (!f || pr_m[i] < best)) begin
                f = 1'b1; best = pr_m[i]; id = 8'(i);
            end
        end
        return {f, id};
    endfunction

    function automatic logic [31:0] exp_bank(input logic [NI-1:0] v, input int bk);
        logic [31:0] w = '0;
        for (int i = 0; i < NI; i++) if (i / 32 == bk) w[i % 32] = v[i];
        return w;
    endfunction

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_we = 1'b1;
        model_write(a, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1; bus_we = 1'b0;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        logic [8:0] w;
        w = exp_win();
        chk({req, " irq_o"}, {31'd0, irq_o}, {31'd0, w[8]});
        if (w[8]) begin
            chk({req, " irq_id_o"}, {24'd0, irq_id_o}, {24'd0, w[7:0]});
            chk({req, " vec_o"}, vec_o, vb_m + {22'd0, w[7:0], 2'b00});
        end
    endtask

    task automatic do_ack();
        logic [8:0] w;
        w = exp_win();
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
        if (w[8]) pd_m[w[7:0]] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd7321));
        for (int i = 0; i < NI; i++) pr_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 irq_id_o", {24'd0, irq_id_o}, 32'd0);
        chk("R1 vec_o", vec_o, 32'd0);
        chk("R1 wake_o", {31'd0, wake_o}, 32'd0);
        bus_rd(10'h000, rd); chk("R1 ctrl", rd, 32'd0);
        bus_rd(10'h004, rd); chk("R1 base", rd, 32'd0);
        bus_rd(10'h044, rd); chk("R1 enable bank1", rd, 32'd0);
        bus_rd(10'h0C0, rd); chk("R1 pending bank0", rd, 32'd0);
        bus_rd(10'h224, rd); chk("R1 urgency word9", rd, 32'd0);

        // R6 base register and bank mapping
        bus_wr(10'h004, 32'h0000_1000);
        bus_rd(10'h004, rd); chk("R6 base readback", rd, 32'h0000_1000);
        bus_wr(10'h044, 32'h20);
        bus_rd(10'h044, rd); chk("R2 R6 set-enable line 37", rd, 32'h20);
        bus_rd(10'h084, rd); chk("R6 clear-enable bank reads enables", rd, 32'h20);
        bus_wr(10'h044, 32'h0);
        bus_rd(10'h044, rd); chk("R2 zero bits no effect", rd, 32'h20);
        chk("R7 no pending no request", {31'd0, irq_o}, 32'd0);

        // R4, R11, R7, R8 forced pending
        bus_wr(10'h0C4, 32'h20);
        chk("R11 not yet visible", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R11 visible one edge later", {31'd0, irq_o}, 32'd1);
        chk("R7 winner 37", {24'd0, irq_id_o}, 32'd37);
        chk("R8 vector 37", vec_o, 32'h0000_1094);
        bus_rd(10'h0C4, rd); chk("R4 pending readback", rd, 32'h20);
        bus_rd(10'h104, rd); chk("R4 clear-pending bank reads pending", rd, 32'h20);

        // R3 disable
        bus_wr(10'h084, 32'h20); settle();
        chk("R3 disabled line silent", {31'd0, irq_o}, 32'd0);
        bus_rd(10'h044, rd); chk("R3 enable cleared", rd, 32'd0);
        bus_rd(10'h0C4, rd); chk("R3 pending kept", rd, 32'h20);
        bus_wr(10'h104, 32'h20);
        bus_rd(10'h0C4, rd); chk("R5 clear-pending", rd, 32'd0);

        // R7 urgency and tie
        bus_wr(10'h200, 32'h0500_0000);
        bus_wr(10'h208, 32'h0002_0000);
        bus_rd(10'h200, rd); chk("R6 urgency word0", rd, 32'h0500_0000);
        bus_wr(10'h040, 32'h0000_0408);
        bus_wr(10'h0C0, 32'h0000_0408); settle();
        chk("R7 lowest value wins", {24'd0, irq_id_o}, 32'd10);
        bus_wr(10'h208, 32'h0005_0000); settle();
        chk("R7 tie lower number", {24'd0, irq_id_o}, 32'd3);
        check_outs("R7 tie");

        // R9 acknowledge
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0; pd_m[3] = 1'b0;
        chk("R9 holdoff", {31'd0, irq_o}, 32'd0);
        bus_rd(10'h0C0, rd); chk("R9 winner pending cleared", rd, 32'h400);
        settle();
        chk("R9 next line", {24'd0, irq_id_o}, 32'd10);
        do_ack(); settle();
        chk("R9 nothing left", {31'd0, irq_o}, 32'd0);

        // R5 edge versus clear in one cycle
        bus_wr(10'h0C0, 32'h80);
        @(negedge clk);
        irq_req[7] = 1'b1; rq_m[7] = 1'b1;
        bus_addr = 10'h100; bus_wdata = 32'h80; bus_sel = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        bus_rd(10'h0C0, rd); chk("R5 edge beats clear", rd, 32'h80);
        bus_wr(10'h100, 32'h80); settle();
        bus_rd(10'h0C0, rd); chk("R5 held level no re-set", rd, 32'd0);

        // R10 wake event
        bus_wr(10'h000, 32'h1);
        bus_rd(10'h000, rd); chk("R10 wake enable readback", rd, 32'h1);
        bus_wr(10'h0C0, 32'h0010_0000);
        chk("R10 wake pulse disabled line", {31'd0, wake_o}, 32'd1);
        @(negedge clk);
        chk("R10 wake one cycle", {31'd0, wake_o}, 32'd0);
        bus_wr(10'h000, 32'h0);
        bus_wr(10'h0C0, 32'h0020_0000);
        chk("R10 wake off", {31'd0, wake_o}, 32'd0);
        settle();

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0: bus_wr(10'h040 + 10'(($urandom % 2) * 4), $urandom & $urandom);
                1: bus_wr(10'h080 + 10'(($urandom % 2) * 4), $urandom & $urandom & $urandom);
                2: bus_wr(10'h0C0 + 10'(($urandom % 2) * 4), $urandom & $urandom);
                3: bus_wr(10'h100 + 10'(($urandom % 2) * 4), $urandom & $urandom);
                4: bus_wr(10'h200 + 10'(($urandom % 10) * 4), $urandom & 32'h0303_0303);
                5: begin
                    int ln;
                    ln = int'($urandom % NI);
                    @(negedge clk);
                    if (!rq_m[ln]) pd_m[ln] = 1'b1;
                    rq_m[ln] = ~rq_m[ln];
                    irq_req[ln] = rq_m[ln];
                end
                6: do_ack();
                default: bus_wr(10'h004, $urandom);
            endcase
            settle();
            check_outs("R7 R8 random");
            bus_rd(10'h0C4, rd); chk("R4 R5 random pending bank1", rd, exp_bank(pd_m, 1));
            bus_rd(10'h040, rd); chk("R2 R3 random enable bank0", rd, exp_bank(en_m, 0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule